// File: doc/BRIEF.md
# Trace message transmit queue

This block buffers debug trace frames between several on-chip producers and a slow off-chip tool. Each producer pushes one frame at a time, tagged with one of four message types. The serializer on the far side pops frames in arrival order. Producers can insert frames faster than the tool removes them, so the queue absorbs bursts of up to sixteen frames.

When a producer pushes into a full queue, the frame is dropped and the block enters overrun. While in overrun, every producer is locked out until the consumer has drained the queue completely. The block then writes one synthesized error frame that carries a mask of the message types that were lost, and normal traffic resumes on the following cycle. The block can also raise a halt request for the CPU as the queue nears full, so that selected message types do not overrun. A control register write carries the debug enable bit, the application reset bit, the per-type trace-enable bits and the per-type halt-select bits. Disabling debug, requesting an application reset, or resetting the debug logic flushes every pending frame.

Top module: `trace_txq`

## Requirements
- R1: Accepted frames leave in arrival order with their type and data. The queue holds up to 16 frames, `level` reports the occupancy, and `pop_valid` is high exactly when `level` is non-zero. An accepted push or pop changes `level` at the clock edge that samples it.
- R2: A push from an active producer is dropped when `level` is 16 at the sampling edge, even if a pop happens in the same cycle. `overrun` is high from that edge onward.
- R3: While `overrun` is high, every producer push is dropped and its type is recorded as lost. Pops continue to drain the queue, and `overrun` stays high after `level` reaches 0.
- R4: At the first edge where `overrun` is high and `level` is 0, the block writes an error frame. The frame has `pop_is_err`=1 and `pop_type`=0. Bits [3:0] of `pop_data` hold the lost mask, where bit i is set if a type-i frame was dropped during this overrun, including a push dropped in that same cycle. All other data bits are 0. `overrun` falls and the mask clears at that edge, and a push in the next cycle is accepted.
- R5: `halt_req` is high exactly while debug is enabled, at least one halt-select bit is set, and `level` is at least 16 minus MAX_MSG (12 by default).
- R6: All pending frames are flushed, and overrun and the lost mask are cleared, on `rst_n` low, on a control write with `ctl_enable`=0, or on a control write with `ctl_app_reset`=1.
- R7: While debug is disabled (after reset or after a write with `ctl_enable`=0), pushes are ignored until a control write with `ctl_enable`=1. Each control write latches `ctl_trace_mode`, where bit i enables type i. A push of a disabled type is ignored completely: it is not queued, it does not cause overrun, and it is not recorded as lost.
- R8: A pop request while the queue is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the debug logic |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_enable | input | 1 | Debug enable bit of the write |
| ctl_app_reset | input | 1 | Application reset request bit of the write |
| ctl_trace_mode | input | 4 | Per-type trace enable bits |
| ctl_halt_sel | input | 4 | Per-type halt-select bits |
| push_valid | input | 1 | Producer push strobe |
| push_type | input | 2 | Message type of the pushed frame |
| push_data | input | 32 | Frame payload |
| pop_req | input | 1 | Consumer pop strobe |
| pop_valid | output | 1 | Queue holds at least one frame |
| pop_data | output | 32 | Payload of the head frame |
| pop_type | output | 2 | Type of the head frame |
| pop_is_err | output | 1 | Head frame is a synthesized error frame |
| level | output | 5 | Current occupancy |
| overrun | output | 1 | Queue is in overrun lockout |
| halt_req | output | 1 | CPU halt request |

## Verification
Ordering is exercised with a vector walk that interleaves pushes and pops of all four types. The walk includes simultaneous push and pop and a pop from an empty queue, so head-of-queue data tells ordering errors apart from pointer or count errors. The overrun sequence fills the queue and pushes into it while popping. It then pushes again during lockout and drains the queue to zero, so the contents of the error mask show whether both drops were recorded and whether lockout was released early. Threshold, flush and trace-mode patterns check the halt edge at 11 and 12 frames, each of the three flush causes, and the difference between a disabled-type push at full occupancy, which is ignored, and an active-type push, which overruns.

// File: rtl/trace_txq_pkg.sv
package trace_txq_pkg;
    localparam int TYPE_W  = 2;
    localparam int NTYPES  = 1 << TYPE_W;
    localparam int FRAME_W = 32;

    typedef struct packed {
        logic              is_err;
        logic [TYPE_W-1:0] typ;
        logic [FRAME_W-1:0] data;
    } frame_t;

    localparam int FRAME_BITS = $bits(frame_t);
endpackage

// File: rtl/txq_store.sv
module txq_store
    import trace_txq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       wr_en,
    input  frame_t                     wr_frame,
    input  logic                       rd_en,
    output frame_t                     rd_frame,
    output logic [$clog2(DEPTH+1)-1:0] level
);
    localparam int PW = $clog2(DEPTH);
    localparam int LW = $clog2(DEPTH+1);

    typedef struct packed {
        logic [PW-1:0] wr_ptr;
        logic [PW-1:0] rd_ptr;
        logic [LW-1:0] level;
    } store_t;

    store_t s_d, s_q;
    logic [FRAME_BITS-1:0] mem_q [DEPTH];
    logic do_rd, do_wr;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        s_d   = s_q;
        do_rd = rd_en && (s_q.level != '0) && !flush;
        do_wr = wr_en && !flush;
        if (flush) begin
            s_d = '0;
        end else begin
            if (do_wr) s_d.wr_ptr = bump(s_q.wr_ptr);
            if (do_rd) s_d.rd_ptr = bump(s_q.rd_ptr);
            case ({do_wr, do_rd})
                2'b10:   s_d.level = s_q.level + 1'b1;
                2'b01:   s_d.level = s_q.level - 1'b1;
                default: s_d.level = s_q.level;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (do_wr) mem_q[s_q.wr_ptr] <= wr_frame;
    end

    assign rd_frame = frame_t'(mem_q[s_q.rd_ptr]);
    assign level    = s_q.level;

    // R1: the controller must never write into a full store
    assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !flush) |-> (s_q.level != LW'(DEPTH)));

    // R8: an empty store does not change level on a pop
    assert_empty_pop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && !flush && s_q.level == '0) |=> (s_q.level == '0));
endmodule

// File: rtl/txq_ctrl.sv
module txq_ctrl
    import trace_txq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       push_valid,
    input  logic [TYPE_W-1:0]          push_type,
    input  logic [FRAME_W-1:0]         push_data,
    input  logic [$clog2(DEPTH+1)-1:0] level,
    output logic                       wr_en,
    output frame_t                     wr_frame,
    output logic                       lock
);
    localparam int LW = $clog2(DEPTH+1);

    typedef struct packed {
        logic              lock;
        logic [NTYPES-1:0] lost;
    } ctrl_t;

    ctrl_t c_d, c_q;
    logic [NTYPES-1:0] drop_bit;
    logic full, empty;

    always_comb begin
        c_d      = c_q;
        wr_en    = 1'b0;
        wr_frame = '0;
        drop_bit = push_valid ? (NTYPES'(1) << push_type) : '0;
        full     = (level == LW'(DEPTH));
        empty    = (level == '0);
        if (flush) begin
            c_d = '0;
        end else if (!c_q.lock) begin
            if (push_valid) begin
                if (!full) begin
                    wr_en         = 1'b1;
                    wr_frame.typ  = push_type;
                    wr_frame.data = push_data;
                end else begin
                    c_d.lock = 1'b1;
                    c_d.lost = c_q.lost | drop_bit;
                end
            end
        end else if (empty) begin
            wr_en           = 1'b1;
            wr_frame.is_err = 1'b1;
            wr_frame.data   = FRAME_W'(c_q.lost | drop_bit);
            c_d.lock        = 1'b0;
            c_d.lost        = '0;
        end else begin
            c_d.lost = c_q.lost | drop_bit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign lock = c_q.lock;

    // R3: no producer frame enters while lockout holds and data remains
    assert_lock_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.lock && !empty) |-> !wr_en);

    // R4: lockout only ends through an error frame write (or a flush)
    assert_err_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(c_q.lock) && !$past(flush)) |-> $past(wr_en && wr_frame.is_err));

    // R2: a push into a full queue enters lockout
    assert_full_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && full && !flush && !c_q.lock) |=> c_q.lock);
endmodule

// File: rtl/trace_txq.sv
module trace_txq
    import trace_txq_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int MAX_MSG = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ctl_wr,
    input  logic                       ctl_enable,
    input  logic                       ctl_app_reset,
    input  logic [NTYPES-1:0]          ctl_trace_mode,
    input  logic [NTYPES-1:0]          ctl_halt_sel,
    input  logic                       push_valid,
    input  logic [TYPE_W-1:0]          push_type,
    input  logic [FRAME_W-1:0]         push_data,
    input  logic                       pop_req,
    output logic                       pop_valid,
    output logic [FRAME_W-1:0]         pop_data,
    output logic [TYPE_W-1:0]          pop_type,
    output logic                       pop_is_err,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output logic                       overrun,
    output logic                       halt_req
);
    localparam int LW     = $clog2(DEPTH+1);
    localparam int THRESH = DEPTH - MAX_MSG;

    typedef struct packed {
        logic              en;
        logic [NTYPES-1:0] mode;
        logic [NTYPES-1:0] halt_sel;
    } cfg_t;

    cfg_t   g_d, g_q;
    logic   flush, push_eff, wr_en, lock;
    frame_t wr_frame, rd_frame;
    logic [LW-1:0] level_w;

    always_comb begin
        g_d   = g_q;
        flush = ctl_wr && (!ctl_enable || ctl_app_reset);
        if (ctl_wr) begin
            g_d.en       = ctl_enable;
            g_d.mode     = ctl_trace_mode;
            g_d.halt_sel = ctl_halt_sel;
        end
        push_eff = push_valid && g_q.en && g_q.mode[push_type];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    txq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push_valid(push_eff), .push_type(push_type), .push_data(push_data),
        .level(level_w), .wr_en(wr_en), .wr_frame(wr_frame), .lock(lock)
    );

    txq_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .wr_en(wr_en), .wr_frame(wr_frame), .rd_en(pop_req),
        .rd_frame(rd_frame), .level(level_w)
    );

    assign level      = level_w;
    assign pop_valid  = (level_w != '0);
    assign pop_data   = rd_frame.data;
    assign pop_type   = rd_frame.typ;
    assign pop_is_err = rd_frame.is_err;
    assign overrun    = lock;
    assign halt_req   = g_q.en && (|g_q.halt_sel) && (level_w >= LW'(THRESH));

    // R6: every flush cause empties the queue at the next edge
    assert_flush_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (level_w == '0 && !lock));

    // R7: nothing is written while debug is disabled
    assert_disabled_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !g_q.en |-> !wr_en);

    // R5: without a config write, halt rises only as occupancy grows
    assert_halt_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(halt_req) && !$past(ctl_wr)) |-> (level_w > $past(level_w)));
endmodule

// File: tb/trace_txq_bench.sv
module trace_txq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr = 0, ctl_enable = 0, ctl_app_reset = 0;
    logic [3:0]  ctl_trace_mode = 0, ctl_halt_sel = 0;
    logic        push_valid = 0;
    logic [1:0]  push_type = 0;
    logic [31:0] push_data = 0;
    logic        pop_req = 0;
    logic        pop_valid, pop_is_err, overrun, halt_req;
    logic [31:0] pop_data;
    logic [1:0]  pop_type;
    logic [4:0]  level;

    int tests = 0, fails = 0;
    bit done = 0;

    always #10 clk = ~clk;

    trace_txq u_trace_txq (.*);

    typedef struct packed {
        logic        push;
        logic [1:0]  typ;
        logic [31:0] data;
        logic        pop;
        logic [4:0]  lvl;
        logic [31:0] head;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{1'b1, 2'd0, 32'hA1, 1'b0, 5'd1, 32'hA1},
        '{1'b1, 2'd1, 32'hB2, 1'b0, 5'd2, 32'hA1},
        '{1'b1, 2'd2, 32'hC3, 1'b1, 5'd2, 32'hB2},
        '{1'b0, 2'd0, 32'h0,  1'b1, 5'd1, 32'hC3},
        '{1'b1, 2'd3, 32'hD4, 1'b1, 5'd1, 32'hD4},
        '{1'b0, 2'd0, 32'h0,  1'b1, 5'd0, 32'h0},
        '{1'b0, 2'd0, 32'h0,  1'b1, 5'd0, 32'h0},
        '{1'b1, 2'd0, 32'hE5, 1'b0, 5'd1, 32'hE5},
        '{1'b0, 2'd0, 32'h0,  1'b1, 5'd0, 32'h0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input logic psh, input logic [1:0] t, input logic [31:0] d, input logic pp);
        push_valid = psh; push_type = t; push_data = d; pop_req = pp;
        @(posedge clk); #1;
        push_valid = 0; pop_req = 0;
    endtask

    task automatic cfg(input logic en, input logic ar, input logic [3:0] md, input logic [3:0] hs);
        ctl_wr = 1; ctl_enable = en; ctl_app_reset = ar; ctl_trace_mode = md; ctl_halt_sel = hs;
        @(posedge clk); #1;
        ctl_wr = 0; ctl_app_reset = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk); #1;
        chk("R6 reset level", level, 0);
        chk("R1 reset pop_valid", pop_valid, 0);
        chk("R3 reset overrun", overrun, 0);
        chk("R5 reset halt", halt_req, 0);
        rst_n = 1;
        @(posedge clk); #1;
        step(1, 0, 32'h11, 0);
        chk("R7 push ignored after reset", level, 0);

        cfg(1, 0, 4'hF, 4'h0);
        foreach (VECS[i]) begin
            step(VECS[i].push, VECS[i].typ, VECS[i].data, VECS[i].pop);
            chk(i == 6 ? "R8 empty pop level" : "R1 vector level", level, VECS[i].lvl);
            if (VECS[i].lvl != 0) chk("R1 vector head", pop_data, VECS[i].head);
        end

        // overrun sequence
        for (int i = 0; i < 16; i++) step(1, 2'(i % 4), 32'h100 + i, 0);
        chk("R1 full level", level, 16);
        chk("R1 head type", pop_type, 0);
        step(1, 2, 32'hBAD, 1);
        chk("R2 drop when full with pop", level, 15);
        chk("R2 overrun set", overrun, 1);
        step(1, 1, 32'hBAD, 0);
        chk("R3 push dropped in lockout", level, 15);
        for (int i = 1; i < 16; i++) begin
            chk("R1 drain order", pop_data, 32'h100 + i);
            step(0, 0, 0, 1);
        end
        chk("R3 drained level", level, 0);
        chk("R3 overrun held when empty", overrun, 1);
        step(0, 0, 0, 0);
        chk("R4 error frame level", level, 1);
        chk("R4 error flag", pop_is_err, 1);
        chk("R4 lost mask", pop_data, 32'h6);
        chk("R4 error type", pop_type, 0);
        chk("R4 overrun cleared", overrun, 0);
        step(1, 3, 32'h77, 0);
        chk("R4 push accepted after error", level, 2);
        step(0, 0, 0, 1);
        chk("R4 normal frame follows", pop_data, 32'h77);
        chk("R4 normal flag", pop_is_err, 0);
        step(0, 0, 0, 1);

        // halt threshold
        cfg(1, 0, 4'hF, 4'h1);
        for (int i = 0; i < 11; i++) step(1, 0, i, 0);
        chk("R5 halt low at 11", halt_req, 0);
        step(1, 0, 32'h55, 0);
        chk("R5 halt high at 12", halt_req, 1);
        step(0, 0, 0, 1);
        chk("R5 halt low after pop", halt_req, 0);
        step(1, 0, 32'h56, 0);
        cfg(1, 0, 4'hF, 4'h0);
        chk("R5 halt low with no select", halt_req, 0);
        chk("R5 config write keeps frames", level, 12);

        // flush causes and trace mode
        cfg(0, 0, 4'hF, 4'h0);
        chk("R6 disable flush", level, 0);
        chk("R6 pop_valid after flush", pop_valid, 0);
        step(1, 0, 32'h9, 0);
        chk("R7 push ignored when disabled", level, 0);
        cfg(1, 0, 4'h1, 4'h0);
        step(1, 2, 32'h9, 0);
        chk("R7 inactive type ignored", level, 0);
        step(1, 0, 32'h9, 0);
        chk("R7 active type accepted", level, 1);
        for (int i = 0; i < 15; i++) step(1, 0, i, 0);
        step(1, 1, 32'hEE, 0);
        chk("R7 inactive type at full", level, 16);
        chk("R7 no overrun from inactive type", overrun, 0);
        cfg(1, 1, 4'hF, 4'h0);
        chk("R6 app reset flush", level, 0);
        step(1, 3, 32'h3, 0);
        step(1, 3, 32'h4, 0);
        chk("R6 refill", level, 2);
        rst_n = 0; #5; rst_n = 1;
        @(posedge clk); #1;
        chk("R6 debug reset flush", level, 0);
        step(1, 3, 32'h5, 0);
        chk("R7 disabled after reset", level, 0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule